// File: doc/BRIEF.md
# Multi-port monitor channel transmitter

This block sends control messages from a CPU out over the monitor sub-channel of a four-port serial telecom interface. Each port has its own transmit register. The register holds a data byte and two flags, ready and last. Each port also has a frame strobe input, and the block moves at most one byte per frame on each port. It presents that byte on the port's byte output for one whole frame. At the next frame boundary it reports completion through a per-port acknowledge status bit.

Software loads a data byte and sets ready, then waits for the acknowledge before it loads the next byte. To close a message, software sets both last and ready. The port then sends the fixed filler value 0xFF with the end-of-message indicator raised, and the stored data byte is not used. A separate abort register holds one bit per port. While a port's abort bit is set, that port drops whatever it is sending and clears its flags.

Top module: `mon_tx_top`

## Requirements
- R1: After reset, every register reads zero, each port's byte output is 0xFF and each end-of-message output is 0.
- R2: Register map. Addresses 0..3 are the port transmit registers, with the data byte in bits 7:0, ready in bit 8 and last in bit 9; bits 15:10 read zero. Address 4 is the abort register, one bit per port in bits 3:0. Address 5 is the acknowledge status register, one bit per port in bits 3:0. The upper bits of both read zero.
- R3: When a port in idle sees a frame strobe while its ready flag is 1 and its last flag is 0, the stored data byte appears on that port's byte output in the next cycle, with end-of-message at 0. The ready flag stays 1 while the byte is being sent.
- R4: The next frame strobe on that port completes the byte. It sets the port's acknowledge status bit and clears its ready flag, and the output returns to 0xFF with end-of-message at 0.
- R5: When ready and last are both 1 at the frame strobe, the port sends 0xFF with end-of-message at 1 for one frame, whatever the stored data byte is. On completion it clears both last and ready and sets the acknowledge bit.
- R6: A CPU write that changes a port's last flag from 1 to 0 also clears its ready flag, whatever value is written to the ready bit.
- R7: While a port's abort bit is set, that port's ready and last flags are cleared and its output goes to 0xFF with end-of-message at 0. No acknowledge is generated, and a transfer in progress is dropped.
- R8: Writing 1 to an acknowledge status bit clears it. Writing 0 leaves it unchanged.
- R9: Between frame strobes a port's outputs hold their value. Traffic on one port does not change another port's outputs.
- R10: A frame strobe on a port whose ready flag is 0 keeps its output at 0xFF with end-of-message at 0, and sets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write enable |
| cpu_addr | input | 3 | Register address, used for both read and write |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data for cpu_addr (combinational) |
| frame_stb | input | 4 | One frame strobe per port |
| tx_byte | output | 32 | Byte output per port; port p uses bits 8p+7:8p |
| tx_eom | output | 4 | End-of-message indicator per port |

## Verification
The bench checks that an end-of-message frame carries the 0xFF filler and not the stored data byte. A design that leaked the data byte would show it next to a raised end-of-message indicator. It checks that clearing last also drops ready; a design without this would go on to send a stale byte as ordinary data. It aborts a port in the middle of a byte and confirms that no acknowledge appears even after further strobes; a design that got this wrong would report a transfer that never finished. It also checks that the outputs of a port hold steady while other ports are strobed, which catches strobe lines wired to the wrong port.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;
    localparam int BYTE_W   = 8;
    localparam int REG_W    = 16;
    localparam int RDY_POS  = 8;
    localparam int LAST_POS = 9;
    localparam logic [BYTE_W-1:0] FILLER = 8'hFF;

    typedef struct packed {
        logic              last;
        logic              ready;
        logic [BYTE_W-1:0] data;
    } chan_reg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    function automatic logic [REG_W-1:0] chan_to_word(chan_reg_t c);
        return {{(REG_W-$bits(chan_reg_t)){1'b0}}, c};
    endfunction
endpackage

// File: rtl/mon_tx_regs.sv
module mon_tx_regs
    import mon_tx_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int AW     = $clog2(NPORTS + 2)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    input  logic [NPORTS-1:0]   done,
    input  logic [NPORTS-1:0]   done_eom,
    output chan_reg_t           chan [NPORTS],
    output logic [NPORTS-1:0]   abort_q
);
    localparam logic [AW-1:0] ABORT_ADDR = AW'(NPORTS);
    localparam logic [AW-1:0] STAT_ADDR  = AW'(NPORTS + 1);

    logic [NPORTS-1:0] ack_q;

    always_ff @(posedge clk) begin
        if (rst)
            abort_q <= '0;
        else if (we && addr == ABORT_ADDR)
            abort_q <= wdata[NPORTS-1:0];
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_chan
        chan_reg_t nxt;
        logic      sel;

        assign sel = we && (addr == AW'(p));

        always_comb begin
            nxt = chan[p];
            if (sel) begin
                nxt.data  = wdata[BYTE_W-1:0];
                nxt.last  = wdata[LAST_POS];
                nxt.ready = wdata[RDY_POS] & (wdata[LAST_POS] | ~chan[p].last);
            end
            if (done[p]) begin
                nxt.ready = 1'b0;
                if (done_eom[p])
                    nxt.last = 1'b0;
            end
            if (abort_q[p]) begin
                nxt.ready = 1'b0;
                nxt.last  = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst)
                chan[p] <= '0;
            else
                chan[p] <= nxt;
        end

        always_ff @(posedge clk) begin
            if (rst)
                ack_q[p] <= 1'b0;
            else if (done[p])
                ack_q[p] <= 1'b1;
            else if (we && addr == STAT_ADDR && wdata[p])
                ack_q[p] <= 1'b0;
        end

        AST_DONE_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
            done[p] |=> !chan[p].ready) else $error("ready survived done");   // R4

        AST_ABORT_NO_ACK: assert property (@(posedge clk) disable iff (rst)
            (abort_q[p] && !ack_q[p]) |=> !ack_q[p]) else $error("ack under abort");   // R7

        AST_LAST_DROP_READY: assert property (@(posedge clk) disable iff (rst)
            (sel && chan[p].last && !wdata[LAST_POS]) |=> !chan[p].ready)
            else $error("ready kept after last cleared");   // R6
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NPORTS; p++)
            if (addr == AW'(p))
                rdata = chan_to_word(chan[p]);
        if (addr == ABORT_ADDR)
            rdata = {{(REG_W-NPORTS){1'b0}}, abort_q};
        if (addr == STAT_ADDR)
            rdata = {{(REG_W-NPORTS){1'b0}}, ack_q};
    end
endmodule

// File: rtl/mon_tx_port.sv
module mon_tx_port
    import mon_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              abort,
    input  chan_reg_t         chan,
    output logic              done,
    output logic              done_eom,
    output logic [BYTE_W-1:0] byte_o,
    output logic              eom_o
);
    tx_state_e state;

    assign done     = (state == ST_SEND) && stb && !abort;
    assign done_eom = done && eom_o;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state  <= ST_IDLE;
            byte_o <= FILLER;
            eom_o  <= 1'b0;
        end else if (stb) begin
            case (state)
                ST_IDLE: begin
                    if (chan.ready) begin
                        state  <= ST_SEND;
                        byte_o <= chan.last ? FILLER : chan.data;
                        eom_o  <= chan.last;
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    byte_o <= FILLER;
                    eom_o  <= 1'b0;
                end
            endcase
        end
    end

    AST_EOM_FILLER: assert property (@(posedge clk) disable iff (rst)
        eom_o |-> (byte_o == FILLER)) else $error("eom without filler");   // R5

    AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (rst)
        (!stb && !abort) |=> ($stable(byte_o) && $stable(eom_o))) else $error("output moved");   // R9

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (byte_o == FILLER && !eom_o)) else $error("abort not idle");   // R7
endmodule

// File: rtl/mon_tx_top.sv
module mon_tx_top
    import mon_tx_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int AW    = $clog2(NPORTS + 2)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_we,
    input  logic [AW-1:0]            cpu_addr,
    input  logic [REG_W-1:0]         cpu_wdata,
    output logic [REG_W-1:0]         cpu_rdata,
    input  logic [NPORTS-1:0]        frame_stb,
    output logic [NPORTS*BYTE_W-1:0] tx_byte,
    output logic [NPORTS-1:0]        tx_eom
);
    chan_reg_t         chan [NPORTS];
    logic [NPORTS-1:0] abort_q;
    logic [NPORTS-1:0] done;
    logic [NPORTS-1:0] done_eom;

    mon_tx_regs #(.NPORTS(NPORTS), .AW(AW)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .we       (cpu_we),
        .addr     (cpu_addr),
        .wdata    (cpu_wdata),
        .rdata    (cpu_rdata),
        .done     (done),
        .done_eom (done_eom),
        .chan     (chan),
        .abort_q  (abort_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        mon_tx_port port_i (
            .clk      (clk),
            .rst      (rst),
            .stb      (frame_stb[p]),
            .abort    (abort_q[p]),
            .chan     (chan[p]),
            .done     (done[p]),
            .done_eom (done_eom[p]),
            .byte_o   (tx_byte[p*BYTE_W +: BYTE_W]),
            .eom_o    (tx_eom[p])
        );
    end
endmodule

// File: tb/mon_tx_top_tb_top.sv
module mon_tx_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_we = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [3:0]  frame_stb = '0;
    logic [31:0] tx_byte;
    logic [3:0]  tx_eom;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mon_tx_top dut_i (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .frame_stb(frame_stb),
        .tx_byte(tx_byte), .tx_eom(tx_eom)
    );

    // {addr, write data, expected read}
    localparam logic [34:0] VEC [6] = '{
        {3'd0, 16'hFFFF, 16'h03FF},
        {3'd1, 16'h02C3, 16'h02C3},
        {3'd2, 16'h0000, 16'h0000},
        {3'd3, 16'hF1F0, 16'h01F0},
        {3'd5, 16'hFFFF, 16'h0000},
        {3'd4, 16'hFFFF, 16'h000F}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [2:0] a, logic [15:0] exp);
        cpu_addr = a;
        #1;
        chk(tag, {16'h0, cpu_rdata}, {16'h0, exp});
    endtask

    task automatic strobe(logic [3:0] m);
        @(negedge clk);
        frame_stb = m;
        @(negedge clk);
        frame_stb = '0;
    endtask

    task automatic out_chk(string tag, int p, logic [7:0] b, logic e);
        chk(tag, {23'h0, tx_eom[p], tx_byte[p*8 +: 8]}, {23'h0, e, b});
    endtask

    initial begin
        #500000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) rd_chk("R1 reg", 3'(a), 16'h0000);
        chk("R1 bytes", tx_byte, 32'hFFFF_FFFF);
        chk("R1 eom", {28'h0, tx_eom}, 32'h0);

        // R2 register map vectors
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][34:32], VEC[i][31:16]);
            rd_chk("R2 map", VEC[i][34:32], VEC[i][15:0]);
        end
        wr(3'd4, 16'h0000);
        rd_chk("R7 abort cleared flags p0", 3'd0, 16'h00FF);
        rd_chk("R7 abort cleared flags p1", 3'd1, 16'h00C3);

        // R10 strobe with nothing ready
        strobe(4'hF);
        chk("R10 idle bytes", tx_byte, 32'hFFFF_FFFF);
        rd_chk("R10 no ack", 3'd5, 16'h0000);

        // R3 byte send on port 0
        wr(3'd0, 16'h01A5);
        strobe(4'b0001);
        out_chk("R3 data out", 0, 8'hA5, 1'b0);
        rd_chk("R3 ready held", 3'd0, 16'h01A5);
        // R9 other ports strobed, port 0 holds
        strobe(4'b1110);
        repeat (3) @(negedge clk);
        out_chk("R9 hold", 0, 8'hA5, 1'b0);
        out_chk("R9 other port idle", 1, 8'hFF, 1'b0);
        // R4 completion
        strobe(4'b0001);
        out_chk("R4 back to idle", 0, 8'hFF, 1'b0);
        rd_chk("R4 ack set", 3'd5, 16'h0001);
        rd_chk("R4 ready cleared", 3'd0, 16'h00A5);
        // R8 write-1-to-clear
        wr(3'd5, 16'h0000);
        rd_chk("R8 zero write keeps", 3'd5, 16'h0001);
        wr(3'd5, 16'h0001);
        rd_chk("R8 one write clears", 3'd5, 16'h0000);

        // R5 end of message on port 1
        wr(3'd1, 16'h0312);
        strobe(4'b0010);
        out_chk("R5 filler with eom", 1, 8'hFF, 1'b1);
        strobe(4'b0010);
        out_chk("R5 eom ended", 1, 8'hFF, 1'b0);
        rd_chk("R5 flags cleared", 3'd1, 16'h0012);
        rd_chk("R5 ack", 3'd5, 16'h0002);
        wr(3'd5, 16'h000F);

        // R6 clearing last drops ready
        wr(3'd2, 16'h0255);
        wr(3'd2, 16'h0155);
        rd_chk("R6 ready dropped", 3'd2, 16'h0055);
        strobe(4'b0100);
        out_chk("R6 nothing sent", 2, 8'hFF, 1'b0);

        // R7 abort mid-transfer on port 3
        wr(3'd3, 16'h0177);
        strobe(4'b1000);
        out_chk("R7 pre-abort data", 3, 8'h77, 1'b0);
        wr(3'd4, 16'h0008);
        @(negedge clk);
        out_chk("R7 output idle", 3, 8'hFF, 1'b0);
        rd_chk("R7 flags cleared", 3'd3, 16'h0077);
        strobe(4'b1000);
        strobe(4'b1000);
        rd_chk("R7 no ack", 3'd5, 16'h0000);
        wr(3'd4, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule